// File: doc/BRIEF.md
# Coarse-Fine Delay Scheduler

This block turns a programmed delay into a timed output edge after each random trigger. For every accepted trigger it takes the preset delay in picoseconds and subtracts the measured trigger-to-clock phase. It then splits the remainder into whole system-clock periods and a sub-period part. The whole periods are counted down by a plain counter. The sub-period part becomes a tap count for a second tapped delay line. When the count expires, a one-cycle launch strobe fires. In the same cycle a thermometer-coded register word is loaded, and that word drives the fine line.

The tapped line spans several clock regions, and each region sees the system clock with a different skew. The block holds a per-region compensation table that is measured relative to a reference region. Before conversion to taps, it subtracts the skew of the region that holds the launching register from the fine part. All arithmetic is unsigned or signed integer picoseconds. While an edge is pending, the block reports busy and ignores further phase measurements.

Top module: `cfd_sched`

## Requirements
- R1: While reset is asserted and right after it is released, `launch`, `busy` and every bit of `tap_word` are 0.
- R2: A `phase_vld` pulse sampled while `busy` is 0 is accepted and sets `busy` from the next cycle on. `busy` stays 1 until the launch cycle and is 0 in the cycle in which `launch` is 1.
- R3: A `phase_vld` sampled while `busy` is 1 is dropped. The pending edge keeps its timing and tap count, and no extra launch follows.
- R4: The remaining delay is `preset_ps - phase_ps`, forced to 0 when the phase exceeds the preset.
- R5: With C = remaining div CLK_PS (after any R7 borrow), `launch` is a single-cycle pulse. It is first seen after the (3 + C)-th rising edge that follows the accepting edge; the accepting edge counts as edge 0.
- R6: The fine part F = remaining mod CLK_PS is turned into a raw tap floor(F / TAP_PS), clamped to NTAPS-1. The region index is raw tap div (NTAPS/NREG), clamped to NREG-1. The region skew (REF_REG - region) * SKEW_PS is subtracted from F.
- R7: If the skew-corrected fine value is negative and C > 0, C is reduced by one and CLK_PS is added to the fine value. If it is negative and C = 0, the fine value becomes 0.
- R8: The tap count is (fine + TAP_PS/2) div TAP_PS, clamped to NTAPS-1, so bit NTAPS-1 of `tap_word` is never set.
- R9: At launch, `tap_word` takes the thermometer code of the tap count: bits [t-1:0] are 1 and all others are 0. It holds that value until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| preset_ps | input | DLY_W | Programmed delay in picoseconds |
| phase_ps | input | PH_W | Corrected trigger-to-clock phase in picoseconds |
| phase_vld | input | 1 | Strobe marking a new phase measurement |
| tap_word | output | NTAPS | Thermometer tap-select word for the fine line |
| launch | output | 1 | One-cycle strobe at the launch edge |
| busy | output | 1 | An edge is pending |

## Verification
The bench overrides NTAPS to 100 and keeps the 10000 ps period, 54 ps tap, five regions and reference region 2, so each region covers 20 taps. With this setting, fine values past about 5.4 ns reach the tap clamp. Phases that leave a fine part below 344 ps fall in region 0 and drive the corrected value negative. That reaches both the coarse borrow and the zero-coarse floor, while mid-range values exercise regions 1 and 2 unclamped. Presets from 100 to 120 ns check the coarse count at ten and eleven periods.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  // Signed clock skew of a region relative to the reference region.
  // Regions below the reference receive the clock later.
  function automatic int skew_of_region(int region, int ref_region, int step_ps);
    return (ref_region - region) * step_ps;
  endfunction

  function automatic int clamp_hi(int v, int hi);
    return (v > hi) ? hi : v;
  endfunction

endpackage

// File: rtl/cfd_remain.sv
module cfd_remain #(
  parameter int DLY_W = 20,
  parameter int PH_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DLY_W-1:0] preset,
  input  logic [PH_W-1:0]  phase,
  output logic [DLY_W-1:0] rem_q,
  output logic             vld_q
);

  logic [DLY_W-1:0] phase_ext;
  logic [DLY_W-1:0] rem_d;

  assign phase_ext = DLY_W'(phase);

  always_comb begin
    if (preset >= phase_ext) rem_d = preset - phase_ext;
    else                     rem_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/cfd_finecalc.sv
module cfd_finecalc #(
  parameter int DLY_W   = 20,
  parameter int CLK_PS  = 10000,
  parameter int TAP_PS  = 54,
  parameter int NTAPS   = 250,
  parameter int NREG    = 5,
  parameter int REF_REG = 2,
  parameter int SKEW_PS = 172,
  parameter int CNT_W   = 7,
  parameter int TAP_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [DLY_W-1:0] rem,
  output logic [CNT_W-1:0] coarse_q,
  output logic [TAP_W-1:0] tap_q,
  output logic             vld_q
);

  localparam int PER_REG = NTAPS / NREG;
  localparam int RG_W    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int SKW_W   = 24;

  // per-region skew compensation table
  logic signed [SKW_W-1:0] skew_tab [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_skew
    assign skew_tab[g] = SKW_W'(cfd_pkg::skew_of_region(g, REF_REG, SKEW_PS));
  end

  int rem_i, crs_i, fin_i, raw_i, reg_i, adj_i, tap_i;
  logic [RG_W-1:0]  reg_sel;
  logic [CNT_W-1:0] coarse_d;
  logic [TAP_W-1:0] tap_d;

  always_comb begin
    rem_i   = int'(rem);
    crs_i   = rem_i / CLK_PS;
    fin_i   = rem_i % CLK_PS;
    raw_i   = cfd_pkg::clamp_hi(fin_i / TAP_PS, NTAPS - 1);
    reg_i   = cfd_pkg::clamp_hi(raw_i / PER_REG, NREG - 1);
    reg_sel = RG_W'(reg_i);
    adj_i   = fin_i - int'(skew_tab[reg_sel]);
    if (adj_i < 0) begin
      if (crs_i > 0) begin
        crs_i = crs_i - 1;
        adj_i = adj_i + CLK_PS;
      end else begin
        adj_i = 0;
      end
    end
    tap_i    = cfd_pkg::clamp_hi((adj_i + TAP_PS / 2) / TAP_PS, NTAPS - 1);
    coarse_d = CNT_W'(crs_i);
    tap_d    = TAP_W'(tap_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      tap_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        coarse_q <= coarse_d;
        tap_q    <= tap_d;
      end
    end
  end

endmodule

// File: rtl/cfd_coarse_cnt.sv
module cfd_coarse_cnt #(
  parameter int CNT_W = 7,
  parameter int TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] coarse_in,
  input  logic [TAP_W-1:0] tap_in,
  output logic             fire,
  output logic             launch_q,
  output logic [TAP_W-1:0] tap_hold
);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TAP_W-1:0] tap_d;

  assign fire = armed_q && (cnt_q == '0);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    tap_d   = tap_hold;
    if (load) begin
      armed_d = 1'b1;
      cnt_d   = coarse_in;
      tap_d   = tap_in;
    end else if (fire) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      tap_hold <= '0;
      launch_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      cnt_q    <= cnt_d;
      tap_hold <= tap_d;
      launch_q <= fire;
    end
  end

endmodule

// File: rtl/cfd_tap_array.sv
module cfd_tap_array #(
  parameter int NTAPS = 250,
  parameter int TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAP_W-1:0] tap,
  output logic [NTAPS-1:0] word
);

  for (genvar g = 0; g < NTAPS; g++) begin : g_bit
    logic bit_d, bit_q;
    assign bit_d = (g < int'(tap));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bit_q <= 1'b0;
      else if (load) bit_q <= bit_d;
    end
    assign word[g] = bit_q;
  end

endmodule

// File: rtl/cfd_sched.sv
module cfd_sched #(
  parameter int DLY_W   = 20,
  parameter int PH_W    = 14,
  parameter int CLK_PS  = 10000,
  parameter int TAP_PS  = 54,
  parameter int NTAPS   = 250,
  parameter int NREG    = 5,
  parameter int REF_REG = 2,
  parameter int SKEW_PS = 172
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] preset_ps,
  input  logic [PH_W-1:0]  phase_ps,
  input  logic             phase_vld,
  output logic [NTAPS-1:0] tap_word,
  output logic             launch,
  output logic             busy
);

  localparam int CNT_W = $clog2((1 << DLY_W) / CLK_PS + 1);
  localparam int TAP_W = $clog2(NTAPS);

  logic             busy_q, busy_d, take, fire;
  logic [DLY_W-1:0] rem;
  logic             rem_vld, calc_vld;
  logic [CNT_W-1:0] coarse;
  logic [TAP_W-1:0] tap_calc, tap_hold;

  assign take = phase_vld && !busy_q;

  always_comb begin
    busy_d = busy_q;
    if (take)      busy_d = 1'b1;
    else if (fire) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;

  cfd_remain #(.DLY_W(DLY_W), .PH_W(PH_W)) u_remain (
    .clk(clk), .rst_n(rst_n), .take(take), .preset(preset_ps),
    .phase(phase_ps), .rem_q(rem), .vld_q(rem_vld)
  );

  cfd_finecalc #(
    .DLY_W(DLY_W), .CLK_PS(CLK_PS), .TAP_PS(TAP_PS), .NTAPS(NTAPS),
    .NREG(NREG), .REF_REG(REF_REG), .SKEW_PS(SKEW_PS),
    .CNT_W(CNT_W), .TAP_W(TAP_W)
  ) u_fine (
    .clk(clk), .rst_n(rst_n), .in_vld(rem_vld), .rem(rem),
    .coarse_q(coarse), .tap_q(tap_calc), .vld_q(calc_vld)
  );

  cfd_coarse_cnt #(.CNT_W(CNT_W), .TAP_W(TAP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(calc_vld), .coarse_in(coarse),
    .tap_in(tap_calc), .fire(fire), .launch_q(launch), .tap_hold(tap_hold)
  );

  cfd_tap_array #(.NTAPS(NTAPS), .TAP_W(TAP_W)) u_taps (
    .clk(clk), .rst_n(rst_n), .load(fire), .tap(tap_hold), .word(tap_word)
  );

endmodule

// File: rtl/cfd_sched_chk.sv
module cfd_sched_chk #(
  parameter int NTAPS = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phase_vld,
  input logic [NTAPS-1:0] tap_word,
  input logic             launch,
  input logic             busy
);

  assert_launch_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!busy && $past(busy)));

  assert_busy_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(phase_vld));

  assert_busy_drop_at_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> launch);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);

  assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |-> $stable(tap_word));

  assert_thermometer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_word & (tap_word + NTAPS'(1))) == '0);

  assert_tap_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_word[NTAPS-1]);

endmodule

bind cfd_sched cfd_sched_chk #(.NTAPS(NTAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld),
  .tap_word(tap_word), .launch(launch), .busy(busy)
);

// File: tb/sim_cfd_sched.sv
module sim_cfd_sched;

  localparam int CLK_PERIOD = 10;
  localparam int NT     = 100;
  localparam int PERIOD = 10000;
  localparam int TAP    = 54;
  localparam int NRG    = 5;
  localparam int REFR   = 2;
  localparam int STEP   = 172;
  localparam int NVEC   = 10;

  // preset / phase pairs (ps)
  localparam int PRESETS [NVEC] = '{110634, 110688, 100000, 5000, 200,
                                    1000, 120000, 101080, 20500, 30400};
  localparam int PHASES  [NVEC] = '{3000, 9500, 0, 2000, 100,
                                    5000, 1500, 0, 0, 300};
  // 0: R8 clamp, region 4   1: R6 region 1   2: R7 borrow   3: R6 reference
  // 4: R7 floor at C=0      5: R4 negative remainder       6: R8 clamp, C=11
  // 7: R6 region 1          8: R6 region 0, C=2            9: R7 borrow, C=3

  logic          clk, rst_n, phase_vld, launch, busy;
  logic [19:0]   preset_ps;
  logic [13:0]   phase_ps;
  logic [NT-1:0] tap_word;

  int n_tests = 0;
  int n_fail  = 0;

  cfd_sched #(.NTAPS(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .preset_ps(preset_ps), .phase_ps(phase_ps),
    .phase_vld(phase_vld), .tap_word(tap_word), .launch(launch), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_calc(input int pr, input int ph, output int c, output int t);
    int rem, f, raw, rg, adj;
    rem = (pr >= ph) ? pr - ph : 0;
    c   = rem / PERIOD;
    f   = rem % PERIOD;
    raw = f / TAP; if (raw > NT-1) raw = NT-1;
    rg  = raw / (NT/NRG); if (rg > NRG-1) rg = NRG-1;
    adj = f - (REFR - rg) * STEP;
    if (adj < 0) begin
      if (c > 0) begin c = c - 1; adj = adj + PERIOD; end
      else adj = 0;
    end
    t = (adj + TAP/2) / TAP; if (t > NT-1) t = NT-1;
  endtask

  function automatic bit word_ok(input logic [NT-1:0] w, input int t);
    for (int i = 0; i < NT; i++)
      if (w[i] !== (i < t)) return 1'b0;
    return 1'b1;
  endfunction

  // Drive one trigger; optionally inject dropped strobes while busy.
  task automatic run_one(input int pr, input int ph, input bit inject);
    int c, t, k;
    bit busy_ok;
    expect_calc(pr, ph, c, t);
    @(negedge clk);
    preset_ps = 20'(pr); phase_ps = 14'(ph); phase_vld = 1'b1;
    k = 0; busy_ok = 1'b1;
    forever begin
      @(negedge clk);
      phase_vld = 1'b0;
      if (inject && (k >= 1) && (k <= 3)) begin
        preset_ps = 20'd9000; phase_ps = 14'd50; phase_vld = 1'b1;
      end
      if (launch || k > 40) break;
      if (!busy) busy_ok = 1'b0;
      k++;
    end
    phase_vld = 1'b0;
    check(k == 3 + c, "R5", "launch cycle", k, 3 + c);
    check(busy_ok, "R2", "busy held until launch", int'(busy_ok), 1);
    check(!busy, "R2", "busy low at launch", int'(busy), 0);
    check(word_ok(tap_word, t), "R9", "tap count", $countones(tap_word), t);
    @(negedge clk);
    check(!launch, "R5", "single-cycle launch", int'(launch), 0);
  endtask

  initial begin
    logic [NT-1:0] held;
    rst_n = 1'b0; phase_vld = 1'b0; preset_ps = '0; phase_ps = '0;
    repeat (3) @(negedge clk);
    check(!launch && !busy && tap_word == '0, "R1", "outputs in reset",
          int'(launch) + int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!launch && !busy && tap_word == '0, "R1", "outputs after reset",
          $countones(tap_word), 0);

    // table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) run_one(PRESETS[i], PHASES[i], 1'b0);

    // R3: strobes while busy are dropped
    run_one(20500, 0, 1'b1);
    held = tap_word;
    begin
      bit extra;
      extra = 1'b0;
      for (int j = 0; j < 30; j++) begin
        @(negedge clk);
        if (launch || busy) extra = 1'b1;
      end
      check(!extra, "R3", "no launch from dropped strobe", int'(extra), 0);
    end
    check(tap_word == held, "R9", "word held between launches",
          $countones(tap_word), $countones(held));

    // R3 again with a long delay, then R9 reload to a different count
    run_one(110688, 9500, 1'b1);
    run_one(5000, 2000, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule